// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the software-visible register face of a serial port. A word-indexed bus with separate read and write strobes reaches its control, status and configuration registers. The block turns a write of the transmit register into a one-cycle character strobe, and it holds exactly one received character delivered through a valid/ready byte handshake. The receive slot can also hold a line-break marker. A single level interrupt line combines the receive-ready and transmit-ready conditions with their enables.

Three status registers track the receive slot together. Status 1 bit 9 and status 2 bit 0 mean "character waiting", and test register bit 5 means "slot empty". Reading the receive register hands out the held value and empties the slot, so the read is destructive. Writing control 2 with bit 0 low returns the whole block to its reset state. Baud and FIFO configuration registers only store what software writes; nothing in the block acts on them.

Top module: `chr_port_regs`

## Requirements
- R1: After reset, reads return: index 0x25 = 0x6040, 0x26 = 0x4028, 0x2D = 0x0060, 0x20 = 0, 0x21 = 0x0001, 0x22 = 0x0700, 0x2A = 0, 0x2B = 0x0004. Index 0x00 returns 0x4000. rx_ready is 1 and irq is 0.
- R2: Indices 0x20, 0x21 (bit 0 aside), 0x22, 0x24, 0x2A and 0x2C keep the low 16 bits of the written word and read them back. The upper bus bits are dropped.
- R3: A character is accepted only in a cycle where rx_valid and rx_ready are both 1. rx_ready equals the inverse of status 1 bit 9. On acceptance, status 1 bit 9 and status 2 bit 0 go to 1, test bit 5 goes to 0, and the byte is held in bits 7:0 of the receive value.
- R4: Reading index 0x00 while the slot is full returns the held value with bit 15 set. The same read clears status 1 bit 9 and status 2 bit 0 and sets test bit 5.
- R5: Reading index 0x00 while the slot is empty returns the held value with bit 15 clear and changes no state.
- R6: A character offered with rx_break = 1 is held as the value 0x0800, whatever rx_data is.
- R7: A write to index 0x10 produces tx_valid = 1 for one cycle, one cycle after the write, with tx_data equal to the low byte written. This happens only when control 2 bit 2 is 1; otherwise the write is dropped.
- R8: Writing index 0x21 with bit 0 = 0 returns every register and the receive slot to the R1 values, except control 2. Control 2 takes the written low 16 bits with bit 0 forced to 1.
- R9: Writing 1s to status 1 can only clear bits of mask 0x9DB0, and writing 1s to status 2 can only clear bits of mask 0xBDD6. All other written status bits, including the receive flags and the reset-time bits, are unchanged.
- R10: irq is 1 exactly when (control 1 bit 9 AND status 1 bit 9) OR (control 1 bit 13 AND control 1 bit 6 AND status 1 bit 13).
- R11: A write to index 0x29 sets the value read at 0x2B. Reads of 0x23 and 0x29 return 0. Writes to 0x23, 0x2B and 0x2D have no effect. Unmapped indices read 0 and ignore writes.
- R12: bus_rdata takes the addressed value on the clock edge that samples bus_rd. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_idx | input | ADDR_W | Register index (byte offset divided by 4) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| tx_valid | output | 1 | Outgoing character strobe |
| tx_data | output | CHAR_W | Outgoing character |
| rx_valid | input | 1 | Incoming character offered |
| rx_ready | output | 1 | Receive slot can take a character |
| rx_data | input | CHAR_W | Incoming character |
| rx_break | input | 1 | Offered item is a line break |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: a 10-bit index, 32-bit data and 8-bit characters. The 10-bit index lets the bench reach indices far above the decoded set, such as 0x3F3, to check that unmapped reads return 0. The 32-bit data path lets it write nonzero upper halves and see them dropped from the 16-bit registers. With 8-bit characters, random bytes cover every code, including those whose bit pattern overlaps the break marker's low byte.

// File: rtl/chr_port_pkg.sv
package chr_port_pkg;

   localparam int unsigned REG_W = 16;
   typedef logic [REG_W-1:0] reg16_t;

   // register indices (byte offset / 4)
   localparam logic [31:0] IDX_RXD  = 32'h00;
   localparam logic [31:0] IDX_TXD  = 32'h10;
   localparam logic [31:0] IDX_CTL1 = 32'h20;
   localparam logic [31:0] IDX_CTL2 = 32'h21;
   localparam logic [31:0] IDX_CTL3 = 32'h22;
   localparam logic [31:0] IDX_CTL4 = 32'h23;
   localparam logic [31:0] IDX_FIFO = 32'h24;
   localparam logic [31:0] IDX_ST1  = 32'h25;
   localparam logic [31:0] IDX_ST2  = 32'h26;
   localparam logic [31:0] IDX_BINC = 32'h29;
   localparam logic [31:0] IDX_BMOD = 32'h2A;
   localparam logic [31:0] IDX_BCNT = 32'h2B;
   localparam logic [31:0] IDX_MSEC = 32'h2C;
   localparam logic [31:0] IDX_TEST = 32'h2D;

   typedef enum logic [3:0] {
      SEL_NONE, SEL_RXD, SEL_TXD, SEL_CTL1, SEL_CTL2, SEL_CTL3, SEL_CTL4,
      SEL_FIFO, SEL_ST1, SEL_ST2, SEL_BINC, SEL_BMOD, SEL_BCNT, SEL_MSEC,
      SEL_TEST
   } sel_e;

   // bit positions other logic depends on
   localparam int unsigned BIT_TXRDY   = 13;  // status 1
   localparam int unsigned BIT_RXRDY   = 9;   // status 1
   localparam int unsigned BIT_RDR     = 0;   // status 2
   localparam int unsigned BIT_RXEMPTY = 5;   // test register
   localparam int unsigned BIT_TXMTEN  = 6;   // control 1
   localparam int unsigned BIT_TXEN    = 2;   // control 2
   localparam int unsigned BIT_SRST    = 0;   // control 2
   localparam int unsigned BIT_CHRDY   = 15;  // receive value

   localparam reg16_t ST1_RST   = 16'h6040;
   localparam reg16_t ST2_RST   = 16'h4028;
   localparam reg16_t TEST_RST  = 16'h0060;
   localparam reg16_t CTL1_RST  = 16'h0000;
   localparam reg16_t CTL2_RST  = 16'h0001;
   localparam reg16_t CTL3_RST  = 16'h0700;
   localparam reg16_t BMOD_RST  = 16'h0000;
   localparam reg16_t BCNT_RST  = 16'h0004;
   localparam reg16_t HOLD_RST  = 16'h4000;
   localparam reg16_t BREAK_VAL = 16'h0800;

   localparam reg16_t ST1_W1C   = 16'h9DB0;
   localparam reg16_t ST2_W1C   = 16'hBDD6;

   function automatic sel_e f_decode(input logic [31:0] idx);
      case (idx)
         IDX_RXD:  return SEL_RXD;
         IDX_TXD:  return SEL_TXD;
         IDX_CTL1: return SEL_CTL1;
         IDX_CTL2: return SEL_CTL2;
         IDX_CTL3: return SEL_CTL3;
         IDX_CTL4: return SEL_CTL4;
         IDX_FIFO: return SEL_FIFO;
         IDX_ST1:  return SEL_ST1;
         IDX_ST2:  return SEL_ST2;
         IDX_BINC: return SEL_BINC;
         IDX_BMOD: return SEL_BMOD;
         IDX_BCNT: return SEL_BCNT;
         IDX_MSEC: return SEL_MSEC;
         IDX_TEST: return SEL_TEST;
         default:  return SEL_NONE;
      endcase
   endfunction

endpackage

// File: rtl/chr_w1c_bank.sv
module chr_w1c_bank #(
   parameter int unsigned W = 16,
   parameter logic [W-1:0] RST_VAL = '0,
   parameter logic [W-1:0] CLR_MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         soft_rst,
   input  logic         wr_clr,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] set_vec,
   input  logic [W-1:0] clr_vec,
   output logic [W-1:0] q
);

   initial begin
      assert (W >= 1 && W <= 64) else $error("chr_w1c_bank: W out of range");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic bit_q;
      if (CLR_MASK[i]) begin : g_clearable
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 bit_q <= RST_VAL[i];
            else if (soft_rst)          bit_q <= RST_VAL[i];
            else if (set_vec[i])        bit_q <= 1'b1;
            else if (clr_vec[i])        bit_q <= 1'b0;
            else if (wr_clr && wdata[i]) bit_q <= 1'b0;
         end
      end else begin : g_fixed
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          bit_q <= RST_VAL[i];
            else if (soft_rst)   bit_q <= RST_VAL[i];
            else if (set_vec[i]) bit_q <= 1'b1;
            else if (clr_vec[i]) bit_q <= 1'b0;
         end
      end
      assign q[i] = bit_q;
   end

   AST_W1C_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && !soft_rst && set_vec == '0 && clr_vec == '0)
      |=> ((q & ~CLR_MASK) == ($past(q) & ~CLR_MASK))); // R9

endmodule

// File: rtl/chr_rx_hold.sv
module chr_rx_hold
   import chr_port_pkg::*;
#(
   parameter int unsigned CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_data,
   input  logic              rx_break,
   input  logic              slot_busy,
   input  logic              slot_empty,
   input  logic              take,
   output logic              rx_ready,
   output logic              accept,
   output logic              taken,
   output reg16_t            rd_val
);

   reg16_t hold_q;

   assign rx_ready = !slot_busy;
   assign accept   = rx_valid && !slot_busy;
   assign taken    = take && !slot_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hold_q <= HOLD_RST;
      else if (soft_rst) hold_q <= HOLD_RST;
      else if (accept)   hold_q <= rx_break ? BREAK_VAL : REG_W'(rx_data);
   end

   always_comb begin
      rd_val = hold_q;
      if (!slot_empty) rd_val[BIT_CHRDY] = 1'b1;
   end

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_ready && !soft_rst) |=> $stable(hold_q)); // R3

   AST_BREAK_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_ready && rx_break && !soft_rst) |=> (hold_q == BREAK_VAL)); // R6

endmodule

// File: rtl/chr_irq_merge.sv
module chr_irq_merge
   import chr_port_pkg::*;
(
   input  reg16_t st1,
   input  reg16_t ctl1,
   output logic   irq
);

   reg16_t cause;

   always_comb begin
      cause = '0;
      cause[BIT_RXRDY] = st1[BIT_RXRDY] & ctl1[BIT_RXRDY];
      cause[BIT_TXRDY] = st1[BIT_TXRDY] & ctl1[BIT_TXRDY] & ctl1[BIT_TXMTEN];
   end

   assign irq = |cause;

endmodule

// File: rtl/chr_port_regs.sv
module chr_port_regs
   import chr_port_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_idx,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              tx_valid,
   output logic [CHAR_W-1:0] tx_data,
   input  logic              rx_valid,
   output logic              rx_ready,
   input  logic [CHAR_W-1:0] rx_data,
   input  logic              rx_break,
   output logic              irq
);

   initial begin
      assert (ADDR_W >= 6 && ADDR_W <= 30) else $error("chr_port_regs: ADDR_W out of range");
      assert (DATA_W >= REG_W) else $error("chr_port_regs: DATA_W below 16");
      assert (CHAR_W >= 5 && CHAR_W <= 8) else $error("chr_port_regs: CHAR_W out of range");
   end

   // ---------------- decode ----------------
   sel_e   sel;
   reg16_t wd16;
   logic   soft_rst;
   logic   take;

   assign sel      = f_decode(32'(bus_idx));
   assign wd16     = bus_wdata[REG_W-1:0];
   assign soft_rst = bus_wr && (sel == SEL_CTL2) && !bus_wdata[BIT_SRST];
   assign take     = bus_rd && (sel == SEL_RXD);

   if (DATA_W > REG_W) begin : g_wide
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^bus_wdata[DATA_W-1:REG_W];
   end

   // ---------------- plain storage registers ----------------
   reg16_t ctl1_q, ctl2_q, ctl3_q, fifo_q, bmod_q, bcnt_q, msec_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl1_q <= CTL1_RST;
         ctl3_q <= CTL3_RST;
         fifo_q <= '0;
         bmod_q <= BMOD_RST;
         bcnt_q <= BCNT_RST;
         msec_q <= '0;
      end else if (soft_rst) begin
         ctl1_q <= CTL1_RST;
         ctl3_q <= CTL3_RST;
         fifo_q <= '0;
         bmod_q <= BMOD_RST;
         bcnt_q <= BCNT_RST;
         msec_q <= '0;
      end else if (bus_wr) begin
         if (sel == SEL_CTL1) ctl1_q <= wd16;
         if (sel == SEL_CTL3) ctl3_q <= wd16;
         if (sel == SEL_FIFO) fifo_q <= wd16;
         if (sel == SEL_BMOD) bmod_q <= wd16;
         if (sel == SEL_BINC) bcnt_q <= wd16;
         if (sel == SEL_MSEC) msec_q <= wd16;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctl2_q <= CTL2_RST;
      else if (bus_wr && sel == SEL_CTL2)
         ctl2_q <= wd16 | REG_W'(1 << BIT_SRST);
   end

   // ---------------- receive slot ----------------
   reg16_t st1_q, st2_q, test_q;
   reg16_t rx_rd_val;
   logic   accept, taken;

   chr_rx_hold #(.CHAR_W(CHAR_W)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst   (soft_rst),
      .rx_valid   (rx_valid),
      .rx_data    (rx_data),
      .rx_break   (rx_break),
      .slot_busy  (st1_q[BIT_RXRDY]),
      .slot_empty (test_q[BIT_RXEMPTY]),
      .take       (take),
      .rx_ready   (rx_ready),
      .accept     (accept),
      .taken      (taken),
      .rd_val     (rx_rd_val)
   );

   // ---------------- status banks ----------------
   reg16_t st1_set, st1_clr, st2_set, st2_clr, tst_set, tst_clr;

   always_comb begin
      st1_set = '0;  st1_set[BIT_RXRDY]   = accept;
      st1_clr = '0;  st1_clr[BIT_RXRDY]   = taken;
      st2_set = '0;  st2_set[BIT_RDR]     = accept;
      st2_clr = '0;  st2_clr[BIT_RDR]     = taken;
      tst_set = '0;  tst_set[BIT_RXEMPTY] = taken;
      tst_clr = '0;  tst_clr[BIT_RXEMPTY] = accept;
   end

   chr_w1c_bank #(.W(REG_W), .RST_VAL(ST1_RST), .CLR_MASK(ST1_W1C)) u_st1 (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .wr_clr(bus_wr && sel == SEL_ST1), .wdata(wd16),
      .set_vec(st1_set), .clr_vec(st1_clr), .q(st1_q)
   );

   chr_w1c_bank #(.W(REG_W), .RST_VAL(ST2_RST), .CLR_MASK(ST2_W1C)) u_st2 (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .wr_clr(bus_wr && sel == SEL_ST2), .wdata(wd16),
      .set_vec(st2_set), .clr_vec(st2_clr), .q(st2_q)
   );

   chr_w1c_bank #(.W(REG_W), .RST_VAL(TEST_RST), .CLR_MASK('0)) u_test (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .wr_clr(1'b0), .wdata(wd16),
      .set_vec(tst_set), .clr_vec(tst_clr), .q(test_q)
   );

   // ---------------- transmit ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_valid <= 1'b0;
         tx_data  <= '0;
      end else begin
         tx_valid <= bus_wr && (sel == SEL_TXD) && ctl2_q[BIT_TXEN];
         if (bus_wr && sel == SEL_TXD && ctl2_q[BIT_TXEN])
            tx_data <= bus_wdata[CHAR_W-1:0];
      end
   end

   // ---------------- read path ----------------
   reg16_t rd16;

   always_comb begin
      unique case (sel)
         SEL_RXD:  rd16 = rx_rd_val;
         SEL_CTL1: rd16 = ctl1_q;
         SEL_CTL2: rd16 = ctl2_q;
         SEL_CTL3: rd16 = ctl3_q;
         SEL_FIFO: rd16 = fifo_q;
         SEL_ST1:  rd16 = st1_q;
         SEL_ST2:  rd16 = st2_q;
         SEL_BMOD: rd16 = bmod_q;
         SEL_BCNT: rd16 = bcnt_q;
         SEL_MSEC: rd16 = msec_q;
         SEL_TEST: rd16 = test_q;
         default:  rd16 = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= DATA_W'(rd16);
   end

   // ---------------- interrupt ----------------
   chr_irq_merge u_irq (
      .st1  (st1_q),
      .ctl1 (ctl1_q),
      .irq  (irq)
   );

   // ---------------- assertions ----------------
   AST_RX_FLAGS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      (st1_q[BIT_RXRDY] == st2_q[BIT_RDR]) && (st1_q[BIT_RXRDY] == !test_q[BIT_RXEMPTY])); // R3

   AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (take && st1_q[BIT_RXRDY]) |=> (test_q[BIT_RXEMPTY] && rx_ready)); // R4

   AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(bus_wr && sel == SEL_TXD && ctl2_q[BIT_TXEN])); // R7

   AST_SRST_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (ctl1_q == CTL1_RST && st1_q == ST1_RST && bcnt_q == BCNT_RST
                    && rx_ready && ctl2_q[BIT_SRST])); // R8

   AST_IRQ_TXGATE: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(ctl1_q[BIT_RXRDY] && st1_q[BIT_RXRDY])) |-> ctl1_q[BIT_TXMTEN]); // R10

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata)); // R12

endmodule

// File: tb/sim_chr_port_regs.sv
module sim_chr_port_regs;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 10;
   localparam int DATA_W = 32;
   localparam int CHAR_W = 8;
   localparam int WDOG_CYCLES = 150000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_idx = '0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic              tx_valid;
   logic [CHAR_W-1:0] tx_data;
   logic              rx_valid = 1'b0;
   logic              rx_ready;
   logic [CHAR_W-1:0] rx_data = '0;
   logic              rx_break = 1'b0;
   logic              irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   chr_port_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_idx(bus_idx), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_break(rx_break),
      .irq(irq)
   );

   // ---------- expected-value functions ----------
   function automatic logic [31:0] f_st1(input bit full);
      return 32'h6040 | (full ? 32'h0200 : 32'h0);
   endfunction

   function automatic logic [31:0] f_st2(input bit full);
      return 32'h4028 | (full ? 32'h0001 : 32'h0);
   endfunction

   function automatic logic [31:0] f_test(input bit full);
      return full ? 32'h0040 : 32'h0060;
   endfunction

   function automatic logic [31:0] f_rxread(input bit full, input logic [15:0] hold);
      return {16'h0, hold | (full ? 16'h8000 : 16'h0)};
   endfunction

   function automatic logic f_irq(input logic [15:0] c1, input bit full);
      return (c1[9] & full) | (c1[13] & c1[6]);
   endfunction

   // ---------- helpers ----------
   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input int idx, input logic [31:0] v);
      @(negedge clk);
      bus_idx = ADDR_W'(idx); bus_wdata = v; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input int idx, output logic [31:0] v);
      @(negedge clk);
      bus_idx = ADDR_W'(idx); bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      v = bus_rdata;
   endtask

   task automatic rx_push(input logic [7:0] d, input logic brk, output bit took);
      @(negedge clk);
      took = rx_ready;
      rx_valid = 1'b1; rx_data = d; rx_break = brk;
      @(negedge clk);
      rx_valid = 1'b0; rx_break = 1'b0;
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   // ---------- watchdog ----------
   initial begin
      repeat (WDOG_CYCLES) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", WDOG_CYCLES);
         summary();
         $finish;
      end
   end

   // ---------- stimulus ----------
   initial begin
      logic [31:0] v;
      bit          took;
      bit          m_full;
      logic [15:0] m_hold;
      logic [15:0] m_ctl1;

      void'($urandom(32'h00C0FFEE));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      check("R1", "rx_ready", 32'(rx_ready), 32'h1);
      check("R1", "irq", 32'(irq), 32'h0);
      bus_read(32'h25, v); check("R1", "status1", v, 32'h6040);
      bus_read(32'h26, v); check("R1", "status2", v, 32'h4028);
      bus_read(32'h2D, v); check("R1", "test", v, 32'h0060);
      bus_read(32'h20, v); check("R1", "ctl1", v, 32'h0);
      bus_read(32'h21, v); check("R1", "ctl2", v, 32'h0001);
      bus_read(32'h22, v); check("R1", "ctl3", v, 32'h0700);
      bus_read(32'h2A, v); check("R1", "modulator", v, 32'h0);
      bus_read(32'h2B, v); check("R1", "baud count", v, 32'h0004);
      bus_read(32'h00, v); check("R5", "empty rx read", v, 32'h4000);

      // R2 storage registers keep low 16 bits
      bus_write(32'h22, 32'hFFFF5A5A); bus_read(32'h22, v); check("R2", "ctl3", v, 32'h5A5A);
      bus_write(32'h24, 32'h12340F0F); bus_read(32'h24, v); check("R2", "fifo ctl", v, 32'h0F0F);
      bus_write(32'h2A, 32'hABCD1357); bus_read(32'h2A, v); check("R2", "modulator", v, 32'h1357);
      bus_write(32'h2C, 32'h0001C350); bus_read(32'h2C, v); check("R2", "msec", v, 32'hC350);
      bus_write(32'h20, 32'hFFFF0001); bus_read(32'h20, v); check("R2", "ctl1", v, 32'h0001);
      bus_write(32'h21, 32'hFFFF8003); bus_read(32'h21, v); check("R2", "ctl2", v, 32'h8003);

      // R11 odd indices
      bus_write(32'h29, 32'h00002468); bus_read(32'h2B, v); check("R11", "count via 0x29", v, 32'h2468);
      bus_read(32'h29, v); check("R11", "read 0x29", v, 32'h0);
      bus_write(32'h2B, 32'h00001111); bus_read(32'h2B, v); check("R11", "write 0x2B ignored", v, 32'h2468);
      bus_write(32'h23, 32'h0000FFFF); bus_read(32'h23, v); check("R11", "read 0x23", v, 32'h0);
      bus_write(32'h2D, 32'h00000000); bus_read(32'h2D, v); check("R11", "write test ignored", v, 32'h0060);
      bus_write(32'h3F3, 32'hDEADBEEF); bus_read(32'h3F3, v); check("R11", "unmapped", v, 32'h0);
      bus_read(32'h20, v); check("R11", "ctl1 after stray writes", v, 32'h0001);

      // R3 / R4 / R5 receive slot
      rx_push(8'h41, 1'b0, took); check("R3", "first accepted", 32'(took), 32'h1);
      check("R3", "ready drops", 32'(rx_ready), 32'h0);
      bus_read(32'h25, v); check("R3", "status1 full", v, 32'h6240);
      bus_read(32'h26, v); check("R3", "status2 full", v, 32'h4029);
      bus_read(32'h2D, v); check("R3", "test full", v, 32'h0040);
      rx_push(8'h42, 1'b0, took); check("R3", "second refused", 32'(took), 32'h0);
      // R9 protected bits while full
      bus_write(32'h25, 32'hFFFFFFFF); bus_read(32'h25, v); check("R9", "status1 w1c", v, 32'h6240);
      bus_write(32'h26, 32'hFFFFFFFF); bus_read(32'h26, v); check("R9", "status2 w1c", v, 32'h4029);
      bus_read(32'h00, v); check("R4", "full rx read", v, 32'h8041);
      check("R4", "ready back", 32'(rx_ready), 32'h1);
      bus_read(32'h25, v); check("R4", "status1 cleared", v, 32'h6040);
      bus_read(32'h2D, v); check("R4", "test empty", v, 32'h0060);
      bus_read(32'h00, v); check("R5", "re-read empty", v, 32'h0041);

      // R6 break
      rx_push(8'h5A, 1'b1, took); check("R6", "break accepted", 32'(took), 32'h1);
      bus_read(32'h00, v); check("R6", "break value", v, 32'h8800);

      // R7 transmit gating
      bus_write(32'h21, 32'h00000005);
      bus_write(32'h10, 32'h000001A5);
      check("R7", "tx_valid enabled", 32'(tx_valid), 32'h1);
      check("R7", "tx_data", 32'(tx_data), 32'hA5);
      @(negedge clk); check("R7", "tx_valid one cycle", 32'(tx_valid), 32'h0);
      bus_write(32'h21, 32'h00000001);
      bus_write(32'h10, 32'h0000003C);
      check("R7", "tx dropped", 32'(tx_valid), 32'h0);

      // R10 interrupt combine
      bus_write(32'h20, 32'h00000200);
      check("R10", "irq rx idle", 32'(irq), 32'h0);
      rx_push(8'h07, 1'b0, took);
      check("R10", "irq rx pending", 32'(irq), 32'h1);
      bus_read(32'h00, v);
      check("R10", "irq after take", 32'(irq), 32'h0);
      bus_write(32'h20, 32'h00002000);
      check("R10", "tx term masked", 32'(irq), 32'h0);
      bus_write(32'h20, 32'h00002040);
      check("R10", "tx term enabled", 32'(irq), 32'h1);

      // R8 software reset
      bus_write(32'h22, 32'h00001111);
      bus_write(32'h29, 32'h00000099);
      rx_push(8'h33, 1'b0, took);
      bus_write(32'h21, 32'h00000004);
      check("R8", "irq cleared", 32'(irq), 32'h0);
      check("R8", "rx_ready", 32'(rx_ready), 32'h1);
      bus_read(32'h21, v); check("R8", "ctl2 forced bit0", v, 32'h0005);
      bus_read(32'h20, v); check("R8", "ctl1", v, 32'h0);
      bus_read(32'h22, v); check("R8", "ctl3", v, 32'h0700);
      bus_read(32'h2B, v); check("R8", "baud count", v, 32'h0004);
      bus_read(32'h25, v); check("R8", "status1", v, 32'h6040);
      bus_read(32'h2D, v); check("R8", "test", v, 32'h0060);
      bus_read(32'h00, v); check("R8", "rx value", v, 32'h4000);

      // constrained random mix
      m_full = 0; m_hold = 16'h4000; m_ctl1 = 16'h0;
      for (int it = 0; it < 400; it++) begin
         int op;
         op = int'($urandom_range(0, 9));
         if (op < 4) begin
            logic [7:0] d;
            logic       b;
            d = 8'($urandom());
            b = ($urandom_range(0, 7) == 0);
            rx_push(d, b, took);
            check("R3", "random accept", 32'(took), 32'(!m_full));
            if (!m_full) begin
               m_hold = b ? 16'h0800 : {8'h0, d};
               m_full = 1;
            end
         end else if (op < 7) begin
            bus_read(32'h00, v);
            check("R4", "random rx read", v, f_rxread(m_full, m_hold));
            m_full = 0;
         end else if (op < 9) begin
            m_ctl1 = 16'($urandom());
            bus_write(32'h20, {16'($urandom()), m_ctl1});
         end else begin
            bus_read(32'h25, v); check("R9", "random status1", v, f_st1(m_full));
            bus_read(32'h26, v); check("R9", "random status2", v, f_st2(m_full));
            bus_read(32'h2D, v); check("R3", "random test", v, f_test(m_full));
         end
         check("R10", "random irq", 32'(irq), 32'(f_irq(m_ctl1, m_full)));
         check("R3", "random ready", 32'(rx_ready), 32'(!m_full));
      end

      // R12 read data holds without a read strobe
      bus_read(32'h22, v);
      repeat (3) @(negedge clk);
      check("R12", "rdata held", bus_rdata, 32'h0700);

      done = 1;
      summary();
      $finish;
   end

endmodule